// File: doc/BRIEF.md
# Periodic Countdown Timer Peripheral

This block is a single-channel countdown timer that software controls through a small 32-bit register port. A prescaler divides the system clock by a programmable power of two. Each prescaled tick decrements the counter. When the counter runs out, a sticky flag is raised, and that flag drives a level-sensitive interrupt line.

Software programs three registers:
- A period register, which holds the number of prescaled ticks per period.
- A control word, which holds the run bit, the auto-repeat bit and the divider select.
- A flag register, which reports and clears the pending event.

In auto-repeat mode the counter reloads itself after each expiry and keeps running. In single-shot mode the run bit drops by itself after the first expiry. The control word reads back as written, so an interrupt handler can toggle the run bit with a read-modify-write. The handler may also rewrite the period register before it acknowledges the flag.

Top module: `tmr_periodic`

## Requirements
- R1: After reset the flag is clear, `irq_o` is 0, and the flag (0x00), period (0x10) and control (0x18) registers all read as 0.
- R2: A read asserted at one clock edge presents its data on `bus_rdata` after that edge. In any cycle with no read, `bus_rdata` is 0.
- R3: Control (0x18) stores bit 7 (run), bit 4 (auto-repeat) and bits 3:0 (divider select). It reads back those bits as written, and all other bits read as 0.
- R4: A divider select value v produces one prescaled tick every 2^(v+1) clock cycles. Example: v=0 divides by 2, v=3 by 16, v=14 by 32768.
- R5: Counting restarts with period N. The flag sets, and `irq_o` (always equal to the flag) goes high, at the N*2^(v+1)-th edge after the restart edge. A period of 0 behaves like 1.
- R6: In auto-repeat mode the counter reloads at expiry and expires again every N*2^(v+1) cycles.
- R7: In single-shot mode (bit 4 = 0) the run bit clears at expiry, which is visible in a control read, and no further expiry occurs.
- R8: Bit 0 of the flag register (0x00) shows the flag, and its other bits read 0. Writing 1 to bit 0 clears the flag. Writing 0 leaves the flag unchanged.
- R9: If an expiry and a write of 1 to bit 0 of the flag register land on the same edge, the flag stays set.
- R10: Two events each copy the period value into the counter and zero the prescaler:
  - a write to the period register (0x10), which is allowed while running;
  - a control write that takes the run bit from 0 to 1.
- R11: Reads from any other offset return 0. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data, 0 when not reading |
| irq_o | output | 1 | Level interrupt, equal to the sticky flag |

## Verification
Read data is due one edge after the read strobe. Flag clears, control updates and restarts take effect at the edge that captures the write. An expiry lands exactly N*2^(v+1) edges after the restart edge. The bench drives each access at a falling edge and counts whole cycles from the capturing edge before it samples, so an expiry is checked both one cycle before it is due and in the cycle it is due. A behavioural model, updated at every rising edge, predicts `irq_o` and `bus_rdata`, and the outputs are compared against it at every falling edge. The same model tells the bench when an expiry is one edge away, so that the same-edge clear case is hit deliberately.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // register byte offsets
   localparam int unsigned OFS_FLAG   = 'h00;
   localparam int unsigned OFS_PERIOD = 'h10;
   localparam int unsigned OFS_CTRL   = 'h18;
   // control bit positions
   localparam int unsigned CTL_RUN_BIT = 7;
   localparam int unsigned CTL_REP_BIT = 4;
   localparam int unsigned FLAG_BIT    = 0;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_FLAG,
      SEL_PERIOD,
      SEL_CTRL
   } reg_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int unsigned SEL_W = 4,
   localparam int unsigned CNT_W = 2 ** SEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   logic [CNT_W-1:0] div_q;
   logic [CNT_W-1:0] mask;

   // bit i of the divider takes part in the tick match when i <= sel
   for (genvar i = 0; i < CNT_W; i++) begin : g_mask
      localparam logic [SEL_W:0] IDX = i;
      assign mask[i] = (IDX <= {1'b0, sel});
   end

   assign tick = run && ((div_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       div_q <= '0;
      else if (restart) div_q <= '0;
      else if (run)     div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] start_val,
   input  logic [CNT_W-1:0] period,
   input  logic             repeat_mode,
   output logic             expire,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   // a count of 1 or 0 runs out on this tick
   assign expire = tick && (cnt_q <= CNT_W'(1));
   assign count  = cnt_q;

   always_comb begin
      cnt_d = cnt_q;
      if (restart)     cnt_d = start_val;
      else if (expire) cnt_d = repeat_mode ? period : '0;
      else if (tick)   cnt_d = cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              expire,
   output logic              run,
   output logic              repeat_mode,
   output logic [SEL_W-1:0]  div_sel,
   output logic              restart,
   output logic [CNT_W-1:0]  start_val,
   output logic [CNT_W-1:0]  period,
   output logic              flag
);
   reg_sel_e          sel;
   logic              wr_flag, wr_period, wr_ctrl;
   logic              run_d;
   logic [DATA_W-1:0] rd_val;

   always_comb begin
      unique case (bus_addr)
         ADDR_W'(OFS_FLAG):   sel = SEL_FLAG;
         ADDR_W'(OFS_PERIOD): sel = SEL_PERIOD;
         ADDR_W'(OFS_CTRL):   sel = SEL_CTRL;
         default:             sel = SEL_NONE;
      endcase
   end

   assign wr_flag   = bus_wr && (sel == SEL_FLAG);
   assign wr_period = bus_wr && (sel == SEL_PERIOD);
   assign wr_ctrl   = bus_wr && (sel == SEL_CTRL);

   assign restart   = wr_period || (wr_ctrl && bus_wdata[CTL_RUN_BIT] && !run);
   assign start_val = wr_period ? bus_wdata[CNT_W-1:0] : period;

   // a control write overrides the single-shot auto-clear
   always_comb begin
      run_d = run;
      if (wr_ctrl)                    run_d = bus_wdata[CTL_RUN_BIT];
      else if (expire && !repeat_mode) run_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run         <= 1'b0;
         repeat_mode <= 1'b0;
         div_sel     <= '0;
         period      <= '0;
         flag        <= 1'b0;
      end else begin
         run <= run_d;
         if (wr_ctrl) begin
            repeat_mode <= bus_wdata[CTL_REP_BIT];
            div_sel     <= bus_wdata[SEL_W-1:0];
         end
         if (wr_period) period <= bus_wdata[CNT_W-1:0];
         // expiry wins over a same-edge clear
         flag <= (flag && !(wr_flag && bus_wdata[FLAG_BIT])) || expire;
      end
   end

   always_comb begin
      rd_val = '0;
      unique case (sel)
         SEL_FLAG:   rd_val[FLAG_BIT] = flag;
         SEL_PERIOD: rd_val[CNT_W-1:0] = period;
         SEL_CTRL: begin
            rd_val[CTL_RUN_BIT] = run;
            rd_val[CTL_REP_BIT] = repeat_mode;
            rd_val[SEL_W-1:0]   = div_sel;
         end
         default:    rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= bus_rd ? rd_val : '0;
   end
endmodule

// File: rtl/tmr_periodic.sv
module tmr_periodic #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   if (DATA_W < 8)         $error("DATA_W must hold the control bits");
   if (CNT_W > DATA_W)     $error("CNT_W must not exceed DATA_W");
   if (SEL_W > 4)          $error("divider select overlaps the mode bit");
   if (ADDR_W < 5)         $error("ADDR_W too small for the register offsets");

   logic             run, repeat_mode, restart, tick, expire, flag;
   logic [SEL_W-1:0] div_sel;
   logic [CNT_W-1:0] start_val, period, count;

   tmr_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .expire(expire), .run(run), .repeat_mode(repeat_mode),
      .div_sel(div_sel), .restart(restart), .start_val(start_val),
      .period(period), .flag(flag)
   );

   tmr_prescaler #(.SEL_W(SEL_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
      .sel(div_sel), .tick(tick)
   );

   tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
      .start_val(start_val), .period(period), .repeat_mode(repeat_mode),
      .expire(expire), .count(count)
   );

   assign irq_o = flag;
endmodule

// File: rtl/tmr_periodic_chk.sv
module tmr_periodic_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned SEL_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              flag,
   input logic              expire,
   input logic              run,
   input logic              repeat_mode,
   input logic [SEL_W-1:0]  div_sel,
   input logic [CNT_W-1:0]  count
);
   logic clr_w1, wr_ctl, wr_per, unmapped;
   assign clr_w1   = bus_wr && (bus_addr == ADDR_W'('h00)) && bus_wdata[0];
   assign wr_ctl   = bus_wr && (bus_addr == ADDR_W'('h18));
   assign wr_per   = bus_wr && (bus_addr == ADDR_W'('h10));
   assign unmapped = (bus_addr != ADDR_W'('h00)) && (bus_addr != ADDR_W'('h10))
                     && (bus_addr != ADDR_W'('h18));

   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_w1) |=> flag);
   a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && clr_w1 && !expire) |=> !flag);
   a_r5_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !expire) |=> !flag);
   a_r9_expire_wins: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag);
   a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && unmapped) |=> (bus_rdata == '0));
   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));
   a_r3_ctrl_fields: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl |=> (repeat_mode == $past(bus_wdata[4]) &&
                  div_sel == $past(bus_wdata[SEL_W-1:0]) &&
                  run == $past(bus_wdata[7])));
   a_r10_period_restart: assert property (@(posedge clk) disable iff (!rst_n)
      wr_per |=> (count == $past(bus_wdata[CNT_W-1:0])));
   a_r7_single_shot_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !repeat_mode && !wr_ctl) |=> !run);
endmodule

bind tmr_periodic tmr_periodic_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
   .flag(flag), .expire(expire), .run(run), .repeat_mode(repeat_mode),
   .div_sel(div_sel), .count(count)
);

// File: tb/tmr_periodic_tb.sv
module tmr_periodic_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  b_addr = '0;
   logic        b_wr = 1'b0;
   logic [31:0] b_wdata = '0;
   logic        b_rd = 1'b0;
   logic [31:0] rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   tmr_periodic u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr),
      .bus_wdata(b_wdata), .bus_rd(b_rd), .bus_rdata(rdata), .irq_o(irq)
   );

   // ---------------- behavioural reference model ----------------
   bit          m_run, m_rep, m_flag;
   int unsigned m_sel, m_div, m_cnt, m_per;
   logic [31:0] m_rdata;

   function automatic int unsigned m_mask();
      return (32'd1 << (m_sel + 1)) - 1;
   endfunction

   function automatic bit m_expire_next();
      return m_run && ((m_div & m_mask()) == m_mask()) && (m_cnt <= 1);
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      case (a)
         8'h00:   return {31'd0, m_flag};
         8'h10:   return m_per;
         8'h18:   return (32'(m_run) << 7) | (32'(m_rep) << 4) | m_sel;
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_rep = 0; m_flag = 0;
         m_sel = 0; m_div = 0; m_cnt = 0; m_per = 0; m_rdata = 0;
      end else begin
         bit tk, ex, wp, wc, wf, rs;
         int unsigned newp;
         tk = m_run && ((m_div & m_mask()) == m_mask());
         ex = tk && (m_cnt <= 1);
         wp = b_wr && b_addr == 8'h10;
         wc = b_wr && b_addr == 8'h18;
         wf = b_wr && b_addr == 8'h00 && b_wdata[0];
         rs = wp || (wc && b_wdata[7] && !m_run);
         newp = wp ? b_wdata : m_per;
         m_rdata = b_rd ? m_read(b_addr) : 32'd0;
         if (rs) begin
            m_cnt = newp; m_div = 0;
         end else if (m_run) begin
            m_div = (m_div + 1) & 32'hFFFF;
            if (ex) m_cnt = m_rep ? m_per : 0;
            else if (tk) m_cnt = m_cnt - 1;
         end
         m_flag = (m_flag && !wf) || ex;
         if (wc) begin
            m_run = b_wdata[7]; m_rep = b_wdata[4]; m_sel = b_wdata[3:0];
         end else if (ex && !m_rep) m_run = 0;
         m_per = newp;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R5 irq vs model", {31'd0, irq}, {31'd0, m_flag});
         check("R2 rdata vs model", rdata, m_rdata);
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      b_wr = 1; b_addr = a; b_wdata = d;
      @(negedge clk);
      b_wr = 0; b_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      b_rd = 1; b_addr = a;
      @(negedge clk);
      d = rdata;
      b_rd = 0;
   endtask

   task automatic skip(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      skip(3);
      rst_n = 1;
      skip(1);
      // R1 reset state
      check("R1 irq", {31'd0, irq}, 32'd0);
      rd(8'h00, v); check("R1 flag reg", v, 32'd0);
      rd(8'h10, v); check("R1 period reg", v, 32'd0);
      rd(8'h18, v); check("R1 ctrl reg", v, 32'd0);
      skip(1); check("R2 idle rdata", rdata, 32'd0);
      // R3 readback of stored fields only
      wr(8'h18, 32'hFFFF_FF1E); rd(8'h18, v); check("R3 ctrl readback", v, 32'h0000_001E);
      wr(8'h18, 32'h0000_006F); rd(8'h18, v); check("R3 ctrl readback 2", v, 32'h0000_000F);
      wr(8'h18, 32'h0);
      // R4/R5 divide by 2, period 3 -> 6 edges
      wr(8'h10, 32'd3);
      wr(8'h18, 32'h90);
      skip(5); check("R5 before expiry", {31'd0, irq}, 32'd0);
      skip(1); check("R5 at expiry", {31'd0, irq}, 32'd1);
      rd(8'h00, v); check("R8 flag bit", v, 32'd1);
      wr(8'h00, 32'hFFFF_FFFE); check("R8 write 0 keeps flag", {31'd0, irq}, 32'd1);
      wr(8'h00, 32'h1); check("R8 write 1 clears", {31'd0, irq}, 32'd0);
      skip(2); check("R6 before reload expiry", {31'd0, irq}, 32'd0);
      skip(1); check("R6 periodic expiry", {31'd0, irq}, 32'd1);
      // R9 clear on the expiry edge
      while (!m_expire_next()) @(negedge clk);
      wr(8'h00, 32'h1); check("R9 expiry beats clear", {31'd0, irq}, 32'd1);
      wr(8'h00, 32'h1); check("R9 later clear", {31'd0, irq}, 32'd0);
      // R10 period rewrite while running restarts the count
      wr(8'h18, 32'h0);
      wr(8'h10, 32'd4);
      wr(8'h18, 32'h90);
      skip(4);
      wr(8'h10, 32'd2);
      skip(3); check("R10 old period ignored", {31'd0, irq}, 32'd0);
      skip(1); check("R10 new period expiry", {31'd0, irq}, 32'd1);
      rd(8'h10, v); check("R10 period readback", v, 32'd2);
      // R4/R7 divide by 16, single shot
      wr(8'h18, 32'h0);
      wr(8'h00, 32'h1);
      wr(8'h18, 32'h83);
      skip(31); check("R4 div16 before", {31'd0, irq}, 32'd0);
      skip(1);  check("R4 div16 expiry", {31'd0, irq}, 32'd1);
      rd(8'h18, v); check("R7 run bit cleared", v, 32'h03);
      wr(8'h00, 32'h1);
      skip(80); check("R7 no further expiry", {31'd0, irq}, 32'd0);
      // R11 unmapped offsets
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h1C, 32'hFFFF_FFFF);
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h14, v); check("R11 unmapped read", v, 32'd0);
      rd(8'h10, v); check("R11 period untouched", v, 32'd2);
      rd(8'h18, v); check("R11 ctrl untouched", v, 32'h03);
      skip(40); check("R11 no restart", {31'd0, irq}, 32'd0);
      finish_run();
   end
endmodule